// File: doc/BRIEF.md
# Next Fetch Address Selector

This block decides where a 32-bit core with word-aligned instructions fetches next. It receives the current fetch address, the decoded control-flow class of the instruction, and the three possible target sources. The sources are a 16-bit signed word offset for compare-and-branch, a 26-bit word index for region-local jumps, and a full register value for indirect jumps. It also receives the two register operands that a conditional branch compares. From these it produces the next fetch address in the same cycle.

For the two linking jump classes it also produces a register-file write request. The request holds an enable, a destination index and the return address, which is the address of the following instruction. The block is purely combinational. It sits between decode and the fetch address register, and it holds no state.

Top module: `nxpc_unit`

## Requirements
- R1: With class code 0 (sequential) or the unused code 7, `pc_next` equals `pc_cur + 4` modulo 2^32, and `link_we` is 0.
- R2: Class code 1 (branch if equal) goes to `pc_cur + 4 + 4*sext(br_off)` when `cmp_a == cmp_b`. Otherwise it goes to `pc_cur + 4`.
- R3: Class code 2 (branch if different) goes to `pc_cur + 4 + 4*sext(br_off)` when `cmp_a != cmp_b`. Otherwise it goes to `pc_cur + 4`.
- R4: `br_off` is a two's-complement value. The extremes +32767 and -32768 reach `pc_cur + 4 + 131068` and `pc_cur + 4 - 131072`, and any sum wraps modulo 2^32.
- R5: Class codes 3 (jump) and 4 (jump and link) target an address built from three parts. Bits 31:28 come from `pc_cur + 4`, bits 27:2 are `jmp_field`, and bits 1:0 are zero.
- R6: Class code 5 (register jump) loads `ind_addr` unchanged into `pc_next` and makes no link write.
- R7: Class code 4 (jump and link) asserts `link_we` with `link_idx` = 31 and `link_val` = `pc_cur + 4`.
- R8: Class code 6 (register jump and link) loads `ind_addr` into `pc_next` and sets `link_val` = `pc_cur + 4`. The destination is `jalr_dst` when `jalr_dst_vld` is 1, and register 31 when it is 0.
- R9: A link write whose destination would be register 0 is suppressed, so `link_we` is 0.
- R10: `link_we` is 0 for every class other than 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the instruction being decoded |
| ctl_class | input | 3 | Control-flow class code (0..7, see requirements) |
| br_off | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Word index for region-local jumps |
| ind_addr | input | 32 | Register value for indirect jumps |
| cmp_a | input | 32 | First branch comparison operand |
| cmp_b | input | 32 | Second branch comparison operand |
| jalr_dst_vld | input | 1 | Explicit destination given for register jump and link |
| jalr_dst | input | 5 | Explicit link destination index |
| pc_next | output | 32 | Next fetch address |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register destination index |
| link_val | output | 32 | Return address to be written |

## Verification
The hardest cases to reach from the ports are the wrap-around cases. In these, a branch at the far end of its offset range crosses address zero or the top of the space, or a jump is decoded in the last word of a 256 MB region so that the region bits of the target differ from those of the current address. Random stimulus almost never hits them. Directed vectors therefore place `pc_cur` near 0, near 2^32 and just below a region boundary, and pair those addresses with offsets 0x7FFF and 0x8000. Random vectors force `cmp_b` equal to `cmp_a` about half the time, so that both branch outcomes occur often.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  typedef enum logic [2:0] {
    CF_SEQ  = 3'd0,
    CF_BEQ  = 3'd1,
    CF_BNE  = 3'd2,
    CF_JMP  = 3'd3,
    CF_JAL  = 3'd4,
    CF_JR   = 3'd5,
    CF_JALR = 3'd6,
    CF_RSVD = 3'd7
  } cflow_e;

  function automatic logic cls_links(cflow_e c);
    return (c == CF_JAL) || (c == CF_JALR);
  endfunction

  function automatic logic cls_is_branch(cflow_e c);
    return (c == CF_BEQ) || (c == CF_BNE);
  endfunction

endpackage

// File: rtl/nxpc_target.sv
module nxpc_target #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [IMM_W-1:0]  br_off,
  input  logic [JIDX_W-1:0] jmp_field,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_target,
  output logic [XLEN-1:0]   jmp_target
);
  localparam int ALIGN_W = 2;
  localparam int HI_W    = XLEN - JIDX_W - ALIGN_W;
  localparam int EXT_W   = XLEN - IMM_W - ALIGN_W;

  function automatic logic [XLEN-1:0] step_word(logic [XLEN-1:0] a);
    return a + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] word_disp(logic [IMM_W-1:0] off);
    return {{EXT_W{off[IMM_W-1]}}, off, {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] region_addr(logic [XLEN-1:0] base,
                                                  logic [JIDX_W-1:0] idx);
    return {base[XLEN-1 -: HI_W], idx, {ALIGN_W{1'b0}}};
  endfunction

  always_comb begin
    seq_pc     = step_word(pc_cur);
    br_target  = seq_pc + word_disp(br_off);
    jmp_target = region_addr(seq_pc, jmp_field);
  end
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  input  logic            want_eq,
  input  logic            want_ne,
  output logic            br_taken
);
  logic same;

  always_comb begin
    same     = (cmp_a ^ cmp_b) == '0;
    br_taken = (want_eq & same) | (want_ne & ~same);
  end
endmodule

// File: rtl/nxpc_link.sv
module nxpc_link #(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              do_link,
  input  logic              use_given,
  input  logic [RIDX_W-1:0] given_idx,
  input  logic [XLEN-1:0]   ret_addr,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);
  localparam logic [RIDX_W-1:0] DEF_IDX = RIDX_W'(LINK_REG);

  always_comb begin
    link_idx = use_given ? given_idx : DEF_IDX;
    link_val = ret_addr;
    link_we  = do_link && (link_idx != '0);
  end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int JIDX_W   = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [2:0]        ctl_class,
  input  logic [IMM_W-1:0]  br_off,
  input  logic [JIDX_W-1:0] jmp_field,
  input  logic [XLEN-1:0]   ind_addr,
  input  logic [XLEN-1:0]   cmp_a,
  input  logic [XLEN-1:0]   cmp_b,
  input  logic              jalr_dst_vld,
  input  logic [RIDX_W-1:0] jalr_dst,
  output logic [XLEN-1:0]   pc_next,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);
  import nxpc_pkg::*;

  cflow_e          cls;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;
  logic            br_taken;
  logic            do_link;
  logic            dst_given;

  assign cls       = cflow_e'(ctl_class);
  assign do_link   = cls_links(cls);
  assign dst_given = (cls == CF_JALR) && jalr_dst_vld;

  nxpc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_cur     (pc_cur),
    .br_off     (br_off),
    .jmp_field  (jmp_field),
    .seq_pc     (seq_pc),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  nxpc_cond #(.XLEN(XLEN)) u_cond (
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .want_eq  (cls == CF_BEQ),
    .want_ne  (cls == CF_BNE),
    .br_taken (br_taken)
  );

  nxpc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_link (
    .do_link   (do_link),
    .use_given (dst_given),
    .given_idx (jalr_dst),
    .ret_addr  (seq_pc),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_val  (link_val)
  );

  always_comb begin
    unique case (cls)
      CF_BEQ, CF_BNE: pc_next = br_taken ? br_target : seq_pc;
      CF_JMP, CF_JAL: pc_next = jmp_target;
      CF_JR, CF_JALR: pc_next = ind_addr;
      default:        pc_next = seq_pc;
    endcase
  end
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic [XLEN-1:0]   pc_cur,
  input logic [2:0]        ctl_class,
  input logic [XLEN-1:0]   cmp_a,
  input logic [XLEN-1:0]   cmp_b,
  input logic [XLEN-1:0]   ind_addr,
  input logic [XLEN-1:0]   seq_pc,
  input logic              br_taken,
  input logic [XLEN-1:0]   pc_next,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_idx
);
  logic known;
  assign known = !$isunknown({pc_cur, ctl_class, cmp_a, cmp_b, ind_addr});

  always_comb begin
    if (known) begin
      // R1
      seq_step_chk: assert (!(ctl_class == 3'd0 || ctl_class == 3'd7)
                            || (pc_next == pc_cur + XLEN'(4)))
        else $error("sequential step wrong");
      // R2
      beq_cond_chk: assert (!(ctl_class == 3'd1 && br_taken) || (cmp_a == cmp_b))
        else $error("equal branch taken on unequal operands");
      // R3
      bne_cond_chk: assert (!(ctl_class == 3'd2 && br_taken) || (cmp_a != cmp_b))
        else $error("unequal branch taken on equal operands");
      // R5
      region_keep_chk: assert (!(ctl_class == 3'd3) ||
                               (pc_next[1:0] == 2'b00 && pc_next[XLEN-1 -: 4] == seq_pc[XLEN-1 -: 4]))
        else $error("jump target region or alignment wrong");
      // R6
      ind_load_chk: assert (!(ctl_class == 3'd5) || (pc_next == ind_addr && !link_we))
        else $error("register jump wrong");
      // R9
      no_zero_dst_chk: assert (!link_we || link_idx != '0)
        else $error("link write to register zero");
      // R10
      link_class_chk: assert (!link_we || ctl_class == 3'd4 || ctl_class == 3'd6)
        else $error("link write from non-linking class");
    end
  end
endmodule

bind nxpc_unit nxpc_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .pc_cur    (pc_cur),
  .ctl_class (ctl_class),
  .cmp_a     (cmp_a),
  .cmp_b     (cmp_b),
  .ind_addr  (ind_addr),
  .seq_pc    (seq_pc),
  .br_taken  (br_taken),
  .pc_next   (pc_next),
  .link_we   (link_we),
  .link_idx  (link_idx)
);

// File: tb/nxpc_unit_tb.sv
module nxpc_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pc_cur, ind_addr, cmp_a, cmp_b;
  logic [2:0]  ctl_class;
  logic [15:0] br_off;
  logic [25:0] jmp_field;
  logic        jalr_dst_vld;
  logic [4:0]  jalr_dst;
  logic [31:0] pc_next, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  nxpc_unit u_dut (
    .pc_cur(pc_cur), .ctl_class(ctl_class), .br_off(br_off), .jmp_field(jmp_field),
    .ind_addr(ind_addr), .cmp_a(cmp_a), .cmp_b(cmp_b), .jalr_dst_vld(jalr_dst_vld),
    .jalr_dst(jalr_dst), .pc_next(pc_next), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val)
  );

  function automatic logic [31:0] m_next();
    longint p = longint'(pc_cur);
    longint o = longint'($signed(br_off));
    logic [31:0] p4 = 32'(p + 4);
    case (ctl_class)
      3'd1: return (cmp_a == cmp_b) ? 32'(p + 4 + o * 4) : p4;
      3'd2: return (cmp_a != cmp_b) ? 32'(p + 4 + o * 4) : p4;
      3'd3, 3'd4: return (p4 & 32'hF000_0000) | (32'(jmp_field) * 32'd4);
      3'd5, 3'd6: return ind_addr;
      default: return p4;
    endcase
  endfunction

  function automatic logic [4:0] m_idx();
    if (ctl_class == 3'd6 && jalr_dst_vld) return jalr_dst;
    return 5'd31;
  endfunction

  function automatic logic m_we();
    if (ctl_class != 3'd4 && ctl_class != 3'd6) return 1'b0;
    return m_idx() != 5'd0;
  endfunction

  function automatic string m_req();
    case (ctl_class)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R6";
      3'd6: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] pc, logic [2:0] cls, logic [15:0] off,
                       logic [25:0] jf, logic [31:0] ia, logic [31:0] a,
                       logic [31:0] b, logic dv, logic [4:0] d, string req);
    @(negedge clk);
    pc_cur = pc; ctl_class = cls; br_off = off; jmp_field = jf;
    ind_addr = ia; cmp_a = a; cmp_b = b; jalr_dst_vld = dv; jalr_dst = d;
    #2;
    chk(req, "pc_next", pc_next, m_next());
    chk((cls == 3'd4 || cls == 3'd6) ? "R9" : "R10", "link_we", 32'(link_we), 32'(m_we()));
    if (m_we()) begin
      chk(req, "link_idx", 32'(link_idx), 32'(m_idx()));
      chk(req, "link_val", link_val, pc + 32'd4);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    pc_cur = 0; ctl_class = 0; br_off = 0; jmp_field = 0; ind_addr = 0;
    cmp_a = 0; cmp_b = 0; jalr_dst_vld = 0; jalr_dst = 0;
    @(negedge clk); #2;
    // R1 idle state: zero inputs give address 4 and no write
    chk("R1", "idle pc_next", pc_next, 32'h4);
    chk("R10", "idle link_we", 32'(link_we), 32'h0);

    // R1 wrap at top, reserved code
    apply(32'hFFFF_FFFC, 3'd0, 16'h0, 26'h0, 0, 0, 0, 0, 0, "R1");
    apply(32'h0000_1000, 3'd7, 16'h7FFF, 26'h3FF_FFFF, 32'hDEAD_BEEC, 1, 1, 1, 0, "R1");
    // R4 extremes, taken and wrapping
    apply(32'h0000_1000, 3'd1, 16'h7FFF, 0, 0, 5, 5, 0, 0, "R4");
    apply(32'h0000_1000, 3'd1, 16'h8000, 0, 0, 5, 5, 0, 0, "R4");
    apply(32'hFFFF_0000, 3'd2, 16'h7FFF, 0, 0, 5, 6, 0, 0, "R4");
    apply(32'h0000_0000, 3'd2, 16'hFFFF, 0, 0, 5, 6, 0, 0, "R4");
    // R2 / R3 not taken
    apply(32'h0040_0000, 3'd1, 16'h0010, 0, 0, 1, 2, 0, 0, "R2");
    apply(32'h0040_0000, 3'd2, 16'h0010, 0, 0, 7, 7, 0, 0, "R3");
    // R5 region boundary: last word of region
    apply(32'h7FFF_FFFC, 3'd3, 16'h0, 26'h000_0003, 0, 0, 0, 0, 0, "R5");
    apply(32'h3000_0010, 3'd3, 16'h0, 26'h3FF_FFFF, 0, 0, 0, 0, 0, "R5");
    // R7 jump and link
    apply(32'h1234_5678, 3'd4, 16'h0, 26'h012_3456, 0, 0, 0, 1, 5'd0, "R7");
    // R6 register jump, unaligned value passes unchanged
    apply(32'h0000_0100, 3'd5, 16'h0, 0, 32'hCAFE_F00D, 0, 0, 1, 5'd7, "R6");
    // R8 default and given destination; R9 destination zero
    apply(32'h0000_0200, 3'd6, 16'h0, 0, 32'h8000_0000, 0, 0, 0, 5'd0, "R8");
    apply(32'h0000_0200, 3'd6, 16'h0, 0, 32'h8000_0000, 0, 0, 1, 5'd9, "R8");
    apply(32'h0000_0200, 3'd6, 16'h0, 0, 32'h8000_0000, 0, 0, 1, 5'd0, "R9");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a = $urandom();
      logic [31:0] b = ($urandom_range(1) == 1) ? a : $urandom();
      logic [2:0]  c = 3'($urandom_range(7));
      apply({$urandom()} & 32'hFFFF_FFFC, c, 16'($urandom()), 26'($urandom()),
            $urandom(), a, b, 1'($urandom()), 5'($urandom_range(3) == 0 ? 0 : $urandom()),
            m_req_for(c));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic string m_req_for(logic [2:0] c);
    logic [2:0] save = ctl_class;
    string r;
    ctl_class = c;
    r = m_req();
    ctl_class = save;
    return r;
  endfunction
endmodule